// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block decides which of two reference clock inputs feeds a downstream PLL. Both references are treated as asynchronous signals. A local sampling clock samples each one through a two-flop synchronizer, and an edge detector follows. A per-input counter then measures how long the input has gone without an edge. When that gap reaches a programmable timeout, the input is declared lost.

A configuration write port loads a 2-bit mode field and the timeout field. Two modes force one input regardless of its health. Two modes switch automatically, driven only by the two loss indications:
- The revertive mode always prefers input 0.
- The holding (non-revertive) mode stays on whichever input it is using until that input fails.

The outputs are the selected input index and two loss flags. The flags read zero whenever a forced mode is active.

Top module: `refclk_selector`

## Requirements
- R1: After synchronous reset the mode is 2'b00, `sel_idx` is 0 and both `los_flag` bits are 0.
- R2: With mode 2'b00, `sel_idx` is 0 whatever the state of either input.
- R3: With mode 2'b01, `sel_idx` is 1 whatever the state of either input. It takes this value on the first clock edge after the write.
- R4: Mode 2'b10 (holding) behaves as follows:
  - It moves from input 0 to input 1 only when input 0 is lost and input 1 is not.
  - It stays on input 1 after input 0 recovers.
  - It moves back to input 0 only when input 1 is lost and input 0 is not.
- R5: Mode 2'b11 (revertive) selects input 0 whenever input 0 is not lost. It selects input 1 only while input 0 is lost and input 1 is not.
- R6: A write that moves the mode from a forced mode (bit 1 = 0) to an automatic mode (bit 1 = 1) sets `sel_idx` to 0 on the edge that takes the write. A write from an automatic mode to an automatic mode leaves `sel_idx` unchanged.
- R7: In an automatic mode, when both inputs are lost, `sel_idx` holds its value.
- R8: Loss detection works per input, counted in sampling-clock cycles:
  - Each synchronized edge of an input restarts its counter.
  - The counter saturates at the timeout.
  - The input is lost while the count equals or exceeds the timeout.
  - The loss clears on the next detected edge.
  - `los_flag[i]` reports input i, with bit 0 for input 0.
- R9: While the mode is forced (bit 1 = 0), both `los_flag` bits are 0.
- R10: The timeout field sets the detection threshold, so a gap between input edges is reported only if it reaches the threshold. A written value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle |
| cfg_mode | input | 2 | Mode field written with `cfg_we` |
| cfg_timeout | input | TO_W | Loss timeout in sampling cycles, written with `cfg_we` |
| ref_in | input | 2 | The two reference clocks, asynchronous |
| sel_idx | output | 1 | Index of the selected reference |
| los_flag | output | 2 | Per-input loss flags, zero in forced modes |

## Verification
A wrong edge-counter state shows at `los_flag` within one timeout period. In an automatic mode it also reaches `sel_idx` one cycle later. A wrong selection register is visible on `sel_idx` on the very next clock. A missed re-initialization on a mode write is therefore caught on the edge that takes the write. The bench runs a behavioural model from the raw input waveforms and compares both outputs on every clock. The exact cycles at which a flag rises and clears are therefore checked, as well as the steady states.

// File: rtl/refsel_pkg.sv
// Shared types for the reference clock selector.
package refsel_pkg;
    typedef enum logic [1:0] {
        MODE_FORCE0  = 2'b00,
        MODE_FORCE1  = 2'b01,
        MODE_HOLD    = 2'b10,
        MODE_PREFER0 = 2'b11
    } refsel_mode_e;
endpackage

// File: rtl/refsel_los_det.sv
// Loss-of-signal detector for one reference input.
// Assumes: ref_i is asynchronous to clk; timeout_i is at least 1.
// A two-flop synchronizer and an edge detector feed a saturating gap counter.
module refsel_los_det #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic [TO_W-1:0] timeout_i,
    output logic            los_o
);
    logic [2:0]      smp_q;   // [0] first sync stage, [1] second, [2] previous
    logic            edge_w;
    logic [TO_W-1:0] gap_q;

    // Synchronize the input and keep one more sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= {smp_q[1:0], ref_i};
    end

    assign edge_w = smp_q[1] ^ smp_q[2];

    // Count cycles since the last edge, saturating at the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_q <= '0;
        else if (edge_w)           gap_q <= '0;
        else if (gap_q < timeout_i) gap_q <= gap_q + 1'b1;
    end

    assign los_o = (gap_q >= timeout_i);

    // R8
    los_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_w |=> !los_o);
    // R8
    los_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_o) |-> !$past(edge_w));
endmodule

// File: rtl/refsel_ctrl.sv
// Configuration register and selection state machine.
// Assumes: los_i comes from per-input detectors in the same clock domain.
// Forced modes pin the selection; automatic modes act on los_i only.
module refsel_ctrl
    import refsel_pkg::*;
#(
    parameter int TO_W        = 8,
    parameter int DEF_TIMEOUT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_mode,
    input  logic [TO_W-1:0] cfg_timeout,
    input  logic [1:0]      los_i,
    output logic [TO_W-1:0] timeout_o,
    output logic            sel_o,
    output logic [1:0]      los_flag_o
);
    localparam logic [TO_W-1:0] TO_RST = TO_W'(DEF_TIMEOUT);

    refsel_mode_e    mode_q;
    refsel_mode_e    mode_wr;
    logic            sel_q;
    logic            sel_d;

    assign mode_wr = refsel_mode_e'(cfg_mode);

    // Hold the mode and timeout fields; a zero timeout is stored as one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_FORCE0;
            timeout_o <= TO_RST;
        end else if (cfg_we) begin
            mode_q    <= mode_wr;
            timeout_o <= (cfg_timeout == '0) ? TO_W'(1) : cfg_timeout;
        end
    end

    // Next selection from the mode, the write strobe and the loss indications.
    always_comb begin
        sel_d = sel_q;
        if (cfg_we) begin
            if (!mode_wr[1])     sel_d = mode_wr[0];
            else if (!mode_q[1]) sel_d = 1'b0;
        end else begin
            unique case (mode_q)
                MODE_FORCE0:  sel_d = 1'b0;
                MODE_FORCE1:  sel_d = 1'b1;
                MODE_HOLD: begin
                    if (!sel_q && los_i[0] && !los_i[1])     sel_d = 1'b1;
                    else if (sel_q && los_i[1] && !los_i[0]) sel_d = 1'b0;
                end
                MODE_PREFER0: begin
                    if (!los_i[0])      sel_d = 1'b0;
                    else if (!los_i[1]) sel_d = 1'b1;
                end
                default: sel_d = sel_q;
            endcase
        end
    end

    // Register the selection.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_d;
    end

    assign sel_o      = sel_q;
    assign los_flag_o = mode_q[1] ? los_i : 2'b00;

    // R2
    force0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && mode_q == MODE_FORCE0) |=> !sel_o);
    // R3
    force1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && mode_q == MODE_FORCE1) |=> sel_o);
    // R4
    hold_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && mode_q == MODE_HOLD && !los_i[sel_q]) |=> $stable(sel_o));
    // R5
    prefer0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && mode_q == MODE_PREFER0 && !los_i[0]) |=> !sel_o);
    // R7
    both_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && mode_q[1] && los_i[0] && los_i[1]) |=> $stable(sel_o));
    // R6
    reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !mode_q[1] && cfg_mode[1]) |=> !sel_o);
endmodule

// File: rtl/refclk_selector.sv
// Redundant reference clock selector: two loss detectors and a selection controller.
// Assumes: clk is the local sampling clock, fast enough to see every reference edge.
module refclk_selector #(
    parameter int TO_W        = 8,
    parameter int DEF_TIMEOUT = 16,
    parameter int N_REF       = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_mode,
    input  logic [TO_W-1:0] cfg_timeout,
    input  logic [1:0]      ref_in,
    output logic            sel_idx,
    output logic [1:0]      los_flag
);
    logic [TO_W-1:0]  timeout_w;
    logic [N_REF-1:0] los_w;

    // One detector per reference input.
    for (genvar g = 0; g < N_REF; g++) begin : g_det
        refsel_los_det #(.TO_W(TO_W)) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_i    (ref_in[g]),
            .timeout_i(timeout_w),
            .los_o    (los_w[g])
        );
    end

    refsel_ctrl #(.TO_W(TO_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_mode   (cfg_mode),
        .cfg_timeout(cfg_timeout),
        .los_i      (los_w),
        .timeout_o  (timeout_w),
        .sel_o      (sel_idx),
        .los_flag_o (los_flag)
    );
endmodule

// File: tb/refclk_selector_tb.sv
module refclk_selector_tb;
    localparam int TO_W = 8;
    localparam int DEF_TO = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_mode = 2'b00;
    logic [TO_W-1:0] cfg_timeout = '0;
    logic [1:0]      ref_in = 2'b00;
    logic            sel_idx;
    logic [1:0]      los_flag;

    int checks = 0;
    int failures = 0;
    string phase = "R1";

    always #2 clk = ~clk;   // 250 MHz

    refclk_selector #(.TO_W(TO_W), .DEF_TIMEOUT(DEF_TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_timeout(cfg_timeout), .ref_in(ref_in),
        .sel_idx(sel_idx), .los_flag(los_flag)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stimulus: each reference toggles every hp[i] cycles while run[i] is set.
    int hp[2] = '{2, 2};
    bit run[2] = '{0, 0};
    int tcnt[2] = '{0, 0};
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (run[i]) begin
                tcnt[i]++;
                if (tcnt[i] >= hp[i]) begin
                    ref_in[i] <= ~ref_in[i];
                    tcnt[i] = 0;
                end
            end
        end
    end

    // Behavioural model: sample history, gap lengths, mode and selection.
    bit   hist[2][$];
    int   m_gap[2];
    int   m_to;
    int   m_mode;
    int   m_sel;
    bit   m_valid = 0;
    always @(posedge clk) begin
        bit lost[2];
        bit edge_seen;
        if (!rst_n) begin
            m_mode = 0; m_to = DEF_TO; m_sel = 0;
            for (int i = 0; i < 2; i++) begin
                hist[i] = '{0, 0, 0};
                m_gap[i] = 0;
            end
        end else begin
            for (int i = 0; i < 2; i++) lost[i] = (m_gap[i] >= m_to);
            if (cfg_we) begin
                if (cfg_mode[1] == 1'b0) m_sel = cfg_mode[0];
                else if (m_mode < 2)     m_sel = 0;
            end else begin
                case (m_mode)
                    0: m_sel = 0;
                    1: m_sel = 1;
                    2: begin
                        if (m_sel == 0 && lost[0] && !lost[1]) m_sel = 1;
                        else if (m_sel == 1 && lost[1] && !lost[0]) m_sel = 0;
                    end
                    default: begin
                        if (!lost[0]) m_sel = 0;
                        else if (!lost[1]) m_sel = 1;
                    end
                endcase
            end
            for (int i = 0; i < 2; i++) begin
                edge_seen = (hist[i][$-1] != hist[i][$-2]);
                if (edge_seen) m_gap[i] = 0;
                else if (m_gap[i] < m_to) m_gap[i]++;
            end
            if (cfg_we) begin
                m_mode = cfg_mode;
                m_to = (cfg_timeout == 0) ? 1 : cfg_timeout;
            end
            for (int i = 0; i < 2; i++) begin
                hist[i].push_back(ref_in[i]);
                if (hist[i].size() > 4) void'(hist[i].pop_front());
            end
        end
        m_valid = 1;
    end

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        int exp_flag;
        if (m_valid) begin
            exp_flag = 0;
            if (m_mode >= 2) begin
                if (m_gap[0] >= m_to) exp_flag += 1;
                if (m_gap[1] >= m_to) exp_flag += 2;
            end
            chk({phase, " sel"}, sel_idx, m_sel);
            chk({phase, " los"}, los_flag, exp_flag);
        end
    end

    task automatic cfg(input int mode, input int to);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = mode[1:0]; cfg_timeout = to[TO_W-1:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cnt;
        run[0] = 1; run[1] = 1;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 reset sel", sel_idx, 0);
        chk("R1 reset los", los_flag, 0);

        phase = "R2";
        cfg(0, 8); wait_cyc(5);
        run[0] = 0; wait_cyc(30);
        chk("R2 forced0 with input0 lost", sel_idx, 0);
        phase = "R9";
        chk("R9 flags zero in forced mode", los_flag, 0);

        phase = "R3";
        cfg(1, 8);
        chk("R3 forced1 after write", sel_idx, 1);
        run[1] = 0; wait_cyc(30);
        chk("R3 forced1 with both lost", sel_idx, 1);
        run[0] = 1; run[1] = 1; wait_cyc(10);

        phase = "R6";
        cfg(3, 8);
        chk("R6 forced to auto reinit", sel_idx, 0);
        phase = "R5";
        wait_cyc(10);
        chk("R5 revertive on input0", sel_idx, 0);
        run[0] = 0; wait_cyc(30);
        chk("R5 revertive failover", sel_idx, 1);
        phase = "R8";
        chk("R8 input0 flagged lost", los_flag, 1);
        phase = "R5";
        run[0] = 1; wait_cyc(20);
        chk("R5 revertive return", sel_idx, 0);
        chk("R8 flag cleared", los_flag, 0);

        phase = "R6";
        cfg(1, 8); cfg(2, 8);
        chk("R6 forced1 to holding reinit", sel_idx, 0);
        phase = "R4";
        wait_cyc(10);
        run[0] = 0; wait_cyc(30);
        chk("R4 holding failover", sel_idx, 1);
        run[0] = 1; wait_cyc(20);
        chk("R4 holding stays on input1", sel_idx, 1);
        phase = "R6";
        cfg(2, 8);
        chk("R6 same auto rewrite keeps sel", sel_idx, 1);
        phase = "R4";
        run[1] = 0; wait_cyc(30);
        chk("R4 holding back to input0", sel_idx, 0);
        phase = "R7";
        run[0] = 0; wait_cyc(30);
        chk("R7 both lost hold", sel_idx, 0);
        chk("R7 both flags", los_flag, 3);
        phase = "R4";
        run[1] = 1; wait_cyc(20);
        chk("R4 move to live input1", sel_idx, 1);
        run[0] = 1; wait_cyc(20);

        phase = "R10";
        hp[0] = 20;
        cfg(3, 40); wait_cyc(60);
        cnt = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (los_flag[0]) cnt++;
        end
        chk("R10 long timeout no loss", cnt, 0);
        cfg(3, 10); wait_cyc(5);
        cnt = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (los_flag[0]) cnt++;
        end
        chk("R10 short timeout loss seen", (cnt > 0) ? 1 : 0, 1);
        hp[0] = 2;
        cfg(3, 0); wait_cyc(5);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (los_flag[1]) cnt++;
        end
        chk("R10 zero timeout acts as one", (cnt > 0) ? 1 : 0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule